// File: doc/BRIEF.md
# Lockable Sequenced-Kick Watchdog Timer

This block is a watchdog timer that sits on a simple register-write bus of a small processor subsystem. Each bus write carries a word address, a data word and a write strobe, and every address that reaches the block counts as part of its register region. After power-on the watchdog is idle and cannot fire. Software sets the timeout value and then arms the watchdog with one control write once its own start-up work is finished. From then on a down-counter runs. There is no way for software to stop it, and its timeout value cannot be changed.

Only a two-step unlock reloads the counter. The first key word must be written to the first key address, and the second key word must be written to the second key address as the next write that reaches the block. Single writes, wrong values, a reversed order or any write between the two steps do not reload it. If the counter runs out, the block raises an internal core reset and a board-level reset together and holds them for a fixed number of cycles. That same event is the only thing that disarms the watchdog and returns its settings to their defaults.

Top module: `sqwd_watchdog`

## Requirements
- R1: After reset the watchdog is unarmed, both reset outputs are inactive, and an unarmed watchdog never raises them whatever the bus does.
- R2: A write to word offset 0 with data bit 0 set arms the watchdog (`armed_o` high from the next cycle). A write there with bit 0 clear leaves it unarmed.
- R3: Once armed, no write to offset 0 with any data disarms the watchdog.
- R4: The timeout value N (default 1000) is written at word offset 1 while unarmed. With no valid kick, the reset outputs become active on the (N+1)-th clock edge after the arming edge.
- R5: Writes to offset 1 while armed are ignored, so the timeout stays the value that was held when the watchdog was armed.
- R6: A kick is a write of 16'h5A3C to offset 2 followed by a write of 16'hC3A5 to offset 3 as the next write to the block. Idle cycles between the two writes are allowed. The second write reloads the counter, so expiry moves to the (N+1)-th edge after it.
- R7: A lone second-key write, a wrong data value at either key address, or the two keys in reversed order does not reload the counter.
- R8: Any other write to the block between the first and the second key abandons the sequence, and the second key then does not reload the counter.
- R9: On expiry `core_rst_o` goes high and `board_rst_o` goes low (its default active-low polarity) on the same edge, and both stay active for exactly PULSE_CYC (default 8) cycles.
- R10: Expiry disarms the watchdog and restores the default timeout, and bus writes made while the reset outputs are active have no effect.
- R11: A valid kick whose second write lands on the edge where the count has reached zero prevents the expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | AW (4) | Word offset of the write |
| bus_wdata | input | DW (16) | Write data |
| armed_o | output | 1 | Watchdog is armed and counting |
| core_rst_o | output | 1 | Internal reset request, active high |
| board_rst_o | output | 1 | Board reset output, polarity set by parameter (active low by default) |

## Verification
The checker takes for granted that the bus carries at most one write per cycle and that a write's address and data are valid whenever the strobe is high. It also takes for granted that the power-on reset is applied once at start and is not pulsed again in the middle of a timeout. The stimulus drives the bus only on the falling clock edge, holds every write for exactly one cycle with the strobe low outside it, and asserts power-on reset only at the beginning. Each timeout scenario waits for the reset pulse to end before the next one starts. Kick timing is swept so that the second key lands both just before expiry and on the zero count itself.

// File: rtl/sqwd_pkg.sv
package sqwd_pkg;

   // Decoded view of one bus write; every field is qualified by the strobe.
   typedef struct packed {
      logic any;     // any write reaching the block
      logic ctrl;    // arm register
      logic rld;     // timeout register
      logic key_a;   // first key address
      logic key_b;   // second key address
   } wsel_t;

   typedef enum logic {
      KS_IDLE   = 1'b0,
      KS_PRIMED = 1'b1
   } kick_st_e;

endpackage

// File: rtl/sqwd_decode.sv
module sqwd_decode
   import sqwd_pkg::*;
#(
   parameter int AW       = 4,
   parameter int OFS_CTRL = 0,
   parameter int OFS_RLD  = 1,
   parameter int OFS_KEYA = 2,
   parameter int OFS_KEYB = 3
) (
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   output wsel_t         sel_o
);

   localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
   localparam logic [AW-1:0] A_RLD  = AW'(OFS_RLD);
   localparam logic [AW-1:0] A_KEYA = AW'(OFS_KEYA);
   localparam logic [AW-1:0] A_KEYB = AW'(OFS_KEYB);

   always_comb begin
      sel_o.any   = bus_we;
      sel_o.ctrl  = bus_we && (bus_addr == A_CTRL);
      sel_o.rld   = bus_we && (bus_addr == A_RLD);
      sel_o.key_a = bus_we && (bus_addr == A_KEYA);
      sel_o.key_b = bus_we && (bus_addr == A_KEYB);
   end

endmodule

// File: rtl/sqwd_kick_seq.sv
module sqwd_kick_seq
   import sqwd_pkg::*;
#(
   parameter int           DW    = 16,
   parameter logic [DW-1:0] KEY_A = 16'h5A3C,
   parameter logic [DW-1:0] KEY_B = 16'hC3A5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  wsel_t         sel_i,
   input  logic [DW-1:0] wdata_i,
   output logic          kick_o
);

   kick_st_e st_q;

   // Every write re-evaluates the state: only a fresh first key primes it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= KS_IDLE;
      end else if (clr_i) begin
         st_q <= KS_IDLE;
      end else if (sel_i.any) begin
         st_q <= (sel_i.key_a && (wdata_i == KEY_A)) ? KS_PRIMED : KS_IDLE;
      end
   end

   assign kick_o = (st_q == KS_PRIMED) && sel_i.key_b && (wdata_i == KEY_B);

endmodule

// File: rtl/sqwd_timer.sv
module sqwd_timer
   import sqwd_pkg::*;
#(
   parameter int           DW         = 16,
   parameter logic [DW-1:0] DEF_RELOAD = 16'd1000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  wsel_t         sel_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          kick_i,
   output logic          armed_o,
   output logic          expire_o
);

   logic          armed_q;
   logic [DW-1:0] rld_q;
   logic [DW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         rld_q   <= DEF_RELOAD;
         cnt_q   <= DEF_RELOAD;
      end else if (clr_i) begin
         armed_q <= 1'b0;
         rld_q   <= DEF_RELOAD;
         cnt_q   <= DEF_RELOAD;
      end else if (!armed_q) begin
         // Settings are open only while unarmed; count tracks the setting.
         if (sel_i.rld) begin
            rld_q <= wdata_i;
         end
         if (sel_i.ctrl && wdata_i[0]) begin
            armed_q <= 1'b1;
         end
         cnt_q <= rld_q;
      end else begin
         if (kick_i) begin
            cnt_q <= rld_q;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign armed_o  = armed_q;
   assign expire_o = armed_q && (cnt_q == '0) && !kick_i;

endmodule

// File: rtl/sqwd_stretch.sv
module sqwd_stretch #(
   parameter int PULSE_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic active_o
);

   localparam int PW = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC + 1);

   generate
      if (PULSE_CYC == 1) begin : g_single
         logic act_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_q <= 1'b0;
            end else begin
               act_q <= fire_i;
            end
         end
         assign active_o = act_q;
      end else begin : g_count
         logic [PW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               left_q <= '0;
            end else if (fire_i) begin
               left_q <= PW'(PULSE_CYC);
            end else if (left_q != '0) begin
               left_q <= left_q - 1'b1;
            end
         end
         assign active_o = (left_q != '0);
      end
   endgenerate

endmodule

// File: rtl/sqwd_watchdog.sv
module sqwd_watchdog
   import sqwd_pkg::*;
#(
   parameter int           AW                   = 4,
   parameter int           DW                   = 16,
   parameter int           OFS_CTRL             = 0,
   parameter int           OFS_RLD              = 1,
   parameter int           OFS_KEYA             = 2,
   parameter int           OFS_KEYB             = 3,
   parameter logic [DW-1:0] KEY_A               = 16'h5A3C,
   parameter logic [DW-1:0] KEY_B               = 16'hC3A5,
   parameter logic [DW-1:0] DEF_RELOAD          = 16'd1000,
   parameter int           PULSE_CYC            = 8,
   parameter bit           BOARD_RST_ACTIVE_LOW = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic          armed_o,
   output logic          core_rst_o,
   output logic          board_rst_o
);

   // Elaboration-time parameter checks.
   if (KEY_A == KEY_B) begin : g_bad_keys
      $error("sqwd_watchdog: the two kick keys must differ");
   end
   if (OFS_KEYA == OFS_KEYB || OFS_CTRL == OFS_RLD || OFS_CTRL == OFS_KEYA ||
       OFS_CTRL == OFS_KEYB || OFS_RLD == OFS_KEYA || OFS_RLD == OFS_KEYB) begin : g_bad_map
      $error("sqwd_watchdog: register offsets must be distinct");
   end
   if (OFS_CTRL >= (1 << AW) || OFS_RLD >= (1 << AW) ||
       OFS_KEYA >= (1 << AW) || OFS_KEYB >= (1 << AW)) begin : g_bad_span
      $error("sqwd_watchdog: an offset does not fit the address width");
   end
   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("sqwd_watchdog: reset pulse must last at least one cycle");
   end

   wsel_t sel;
   logic  kick;
   logic  expire;
   logic  bite;
   logic  clr;

   // Expiry and the whole reset pulse hold the watchdog's own state cleared.
   assign clr = expire || bite;

   sqwd_decode #(
      .AW(AW), .OFS_CTRL(OFS_CTRL), .OFS_RLD(OFS_RLD),
      .OFS_KEYA(OFS_KEYA), .OFS_KEYB(OFS_KEYB)
   ) u_decode (
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .sel_o    (sel)
   );

   sqwd_kick_seq #(
      .DW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B)
   ) u_kick (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .sel_i   (sel),
      .wdata_i (bus_wdata),
      .kick_o  (kick)
   );

   sqwd_timer #(
      .DW(DW), .DEF_RELOAD(DEF_RELOAD)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr),
      .sel_i    (sel),
      .wdata_i  (bus_wdata),
      .kick_i   (kick),
      .armed_o  (armed_o),
      .expire_o (expire)
   );

   sqwd_stretch #(
      .PULSE_CYC(PULSE_CYC)
   ) u_stretch (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire_i   (expire),
      .active_o (bite)
   );

   assign core_rst_o = bite;

   generate
      if (BOARD_RST_ACTIVE_LOW) begin : g_brd_low
         assign board_rst_o = ~bite;
      end else begin : g_brd_high
         assign board_rst_o = bite;
      end
   endgenerate

endmodule

// File: rtl/sqwd_checker.sv
module sqwd_checker #(
   parameter int AW                   = 4,
   parameter int OFS_CTRL             = 0,
   parameter int PULSE_CYC            = 8,
   parameter bit BOARD_RST_ACTIVE_LOW = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_we,
   input logic [AW-1:0] bus_addr,
   input logic          arm_bit,
   input logic          armed_o,
   input logic          core_rst_o,
   input logic          board_rst_o
);

   logic brd_active;
   int   hi_run;

   assign brd_active = BOARD_RST_ACTIVE_LOW ? ~board_rst_o : board_rst_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run <= 0;
      end else if (core_rst_o) begin
         hi_run <= hi_run + 1;
      end else begin
         hi_run <= 0;
      end
   end

   // R1: an unarmed, quiet watchdog cannot raise a reset next cycle
   assert_unarmed_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_o && !core_rst_o) |=> !core_rst_o);

   // R2: arming only follows an arm write
   assert_arm_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed_o) |-> $past(bus_we && (bus_addr == AW'(OFS_CTRL)) && arm_bit));

   // R3: disarming happens only together with the reset pulse
   assert_no_disarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(armed_o) |-> core_rst_o);

   // R4: a reset pulse begins only from the armed state
   assert_fire_from_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_rst_o) |-> $past(armed_o));

   // R9: both reset outputs agree every cycle
   assert_outputs_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_o == brd_active);

   // R9: pulse width is exactly the configured number of cycles
   assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rst_o) |-> (hi_run == PULSE_CYC));

   // R10: the watchdog is unarmed throughout the pulse
   assert_unarmed_in_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_o |-> !armed_o);

endmodule

bind sqwd_watchdog sqwd_checker #(
   .AW(AW), .OFS_CTRL(OFS_CTRL), .PULSE_CYC(PULSE_CYC),
   .BOARD_RST_ACTIVE_LOW(BOARD_RST_ACTIVE_LOW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_we      (bus_we),
   .bus_addr    (bus_addr),
   .arm_bit     (bus_wdata[0]),
   .armed_o     (armed_o),
   .core_rst_o  (core_rst_o),
   .board_rst_o (board_rst_o)
);

// File: tb/sim_sqwd_watchdog.sv
module sim_sqwd_watchdog;

   localparam int KEYA_V = 16'h5A3C;
   localparam int KEYB_V = 16'hC3A5;
   localparam int PULSE  = 8;
   localparam int DEFRLD = 1000;
   localparam int A_CTRL = 0;
   localparam int A_RLD  = 1;
   localparam int A_KA   = 2;
   localparam int A_KB   = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        armed_o, core_rst_o, board_rst_o;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";

   sqwd_watchdog u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .armed_o(armed_o), .core_rst_o(core_rst_o),
      .board_rst_o(board_rst_o)
   );

   always #2 clk = ~clk;

   // Behavioural reference state
   bit m_armed, m_primed;
   int m_rld, m_cnt, m_pulse;

   always @(posedge clk) begin
      bit kick, expire, old_armed;
      if (!rst_n) begin
         m_armed = 0; m_primed = 0; m_rld = DEFRLD; m_cnt = DEFRLD; m_pulse = 0;
      end else begin
         kick   = m_primed && bus_we && bus_addr == A_KB && bus_wdata == KEYB_V;
         expire = m_armed && m_cnt == 0 && !kick;
         if (expire || m_pulse > 0) begin
            m_pulse  = expire ? PULSE : m_pulse - 1;
            m_armed  = 0; m_primed = 0; m_rld = DEFRLD; m_cnt = DEFRLD;
         end else begin
            old_armed = m_armed;
            if (bus_we) m_primed = (bus_addr == A_KA && bus_wdata == KEYA_V);
            if (!old_armed) begin
               m_cnt = m_rld;
               if (bus_we && bus_addr == A_RLD) m_rld = bus_wdata;
               if (bus_we && bus_addr == A_CTRL && bus_wdata[0]) m_armed = 1;
            end else if (kick) begin
               m_cnt = m_rld;
            end else begin
               m_cnt = m_cnt - 1;
            end
         end
      end
   end

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n) begin
         chk(armed_o == m_armed, cur_req, "armed_o", armed_o, m_armed);
         chk(core_rst_o == (m_pulse > 0), cur_req, "core_rst_o", core_rst_o, m_pulse > 0);
         chk(board_rst_o == !(m_pulse > 0), cur_req, "board_rst_o", board_rst_o, !(m_pulse > 0));
      end
   end

   task automatic wr(int a, int d);
      bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = 16'(d);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_bite(output int m);
      m = 0;
      while (!core_rst_o && m < 5000) begin
         @(negedge clk);
         m++;
      end
   endtask

   task automatic wait_clear();
      int w = 0;
      while (core_rst_o && w < 100) begin
         @(negedge clk);
         w++;
      end
      idle(2);
   endtask

   initial begin
      int m;
      int hi;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1: reset state and no firing while unarmed
      cur_req = "R1";
      chk(armed_o == 0 && core_rst_o == 0 && board_rst_o == 1, "R1", "reset state", armed_o, 0);
      wr(A_KA, KEYA_V); wr(A_KB, KEYB_V); wr(A_RLD, 3); wr(A_KB, 16'h1234);
      idle(30);
      chk(core_rst_o == 0, "R1", "unarmed no reset", core_rst_o, 0);

      // R2: arm bit clear does nothing, set arms
      cur_req = "R2";
      wr(A_CTRL, 16'hFFFE);
      chk(armed_o == 0, "R2", "arm with bit0 clear", armed_o, 0);
      wr(A_RLD, 12);
      wr(A_CTRL, 1);
      chk(armed_o == 1, "R2", "arm with bit0 set", armed_o, 1);

      // R3 and R5: disarm attempt and reload change while armed
      cur_req = "R5";
      wr(A_RLD, 200);
      cur_req = "R3";
      wr(A_CTRL, 0);
      chk(armed_o == 1, "R3", "still armed after ctrl write", armed_o, 1);
      wait_bite(m);
      chk(m == 11, "R5", "expiry edge with locked timeout", m, 11);

      // R9: pulse width and polarity
      cur_req = "R9";
      chk(board_rst_o == 0, "R9", "board reset active low", board_rst_o, 0);
      hi = 0;
      while (core_rst_o && hi < 100) begin
         @(negedge clk);
         hi++;
      end
      chk(hi == PULSE, "R9", "pulse width", hi, PULSE);
      idle(2);

      // R4 and R10: default timeout restored, writes during pulse ignored
      cur_req = "R10";
      wr(A_CTRL, 1);
      wait_bite(m);
      chk(m == DEFRLD + 1, "R10", "default timeout after bite", m, DEFRLD + 1);
      wr(A_CTRL, 1); wr(A_RLD, 5);
      wait_clear();
      chk(armed_o == 0, "R10", "arm write in pulse ignored", armed_o, 0);
      cur_req = "R4";
      wr(A_CTRL, 1);
      wait_bite(m);
      chk(m == DEFRLD + 1, "R4", "timeout from reload register", m, DEFRLD + 1);
      wait_clear();

      // R6: regular kicks keep it alive, idle between keys allowed
      cur_req = "R6";
      wr(A_RLD, 10); wr(A_CTRL, 1);
      for (int k = 0; k < 8; k++) begin
         idle(k % 4);
         wr(A_KA, KEYA_V);
         idle(k % 3);
         wr(A_KB, KEYB_V);
      end
      chk(core_rst_o == 0 && armed_o == 1, "R6", "kicked watchdog alive", core_rst_o, 0);
      wait_bite(m);
      chk(m == 11, "R6", "expiry after last kick", m, 11);
      wait_clear();

      // R11: second key on the zero-count edge
      cur_req = "R11";
      wr(A_RLD, 10); wr(A_CTRL, 1);
      for (int k = 0; k < 4; k++) begin
         idle(9);
         wr(A_KA, KEYA_V);
         wr(A_KB, KEYB_V);
      end
      chk(core_rst_o == 0, "R11", "tie kick prevents expiry", core_rst_o, 0);
      wait_bite(m);
      wait_clear();

      // R7: invalid kick forms
      cur_req = "R7";
      wr(A_RLD, 20); wr(A_CTRL, 1);
      wr(A_KB, KEYB_V);
      wr(A_KA, 16'h5A3D);
      wr(A_KA, KEYA_V);
      wr(A_KB, 16'hC3A4);
      wr(A_KB, KEYB_V);
      wr(A_KA, KEYA_V);
      wait_bite(m);
      chk(m == 15, "R7", "no reload from bad kicks", m, 15);
      wait_clear();

      // R8: interrupted sequences
      cur_req = "R8";
      wr(A_RLD, 30); wr(A_CTRL, 1);
      for (int k = 0; k < 4; k++) begin
         wr(A_KA, KEYA_V);
         wr((k % 2 == 0) ? A_CTRL : 9, k);
         wr(A_KB, KEYB_V);
      end
      wait_bite(m);
      chk(m == 19, "R8", "no reload after abandoned sequence", m, 19);
      wait_clear();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL %s watchdog expired actual=%0d expected=%0d", cur_req, 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule